// File: doc/BRIEF.md
# Cascaded Biquad IIR Filter Engine

This block filters a stream of signed 24-bit audio samples through a chain of second-order IIR sections, and it uses one shared multiply-accumulate datapath. For each accepted sample the engine visits the sections one after another. In each section it spends five cycles, one for each coefficient tap, and reads each coefficient from an external store through a read port that answers in the same cycle. Every section keeps its own pair of past inputs and pair of past outputs. The output of a section, saturated to 24 bits, becomes the input of the next section.

The chain can be six sections or five sections long. An optional high-pass section has a fixed place in the coefficient store, and that place depends on the signal path. On the converter-input path it is the sixth stored section and always runs last. On the modulator-output path it is the first stored section and always runs first. When the enable input is low, no processing takes place and every delay term is cleared.

Top module: `iir_cascade_engine`

## Requirements
- R1: Each section computes y = (B0·x + B1·x1 + B2·x2 − A1·y1 − A2·y2) >>> 16 at full precision, with an arithmetic shift that rounds towards minus infinity. Coefficients are signed 3.16 values, so 1.0 is 0x0001_0000.
- R2: Coefficients are fetched in the order B0, B1, B2, A1, A2 from word address 5·s + tap, where s is the stored section index (0..5) and tap runs from 0 to 4.
- R3: When `five_stage`=0 and high-pass is off, the stored sections run in the order 0,1,2,3,4,5.
- R4: When `five_stage`=1 and high-pass is off, sections 0 to 4 run and section 5 has no effect on the output.
- R5: When high-pass is on and `path_pwm`=0, the last chain position uses stored section 5. With five stages the order is therefore 0,1,2,3,5.
- R6: When high-pass is on and `path_pwm`=1, stored section 0 (the high-pass) runs first and the order is the same as with high-pass off.
- R7: A sample is accepted on a clock edge where `in_valid`, `enable` and not `busy` all hold. `busy` stays high until `out_valid` rises exactly 5·N edges later, where N is the active section count. `out_valid` is a one-cycle pulse, and `busy` is low while it is high.
- R8: `in_valid` is ignored while `busy` is high: it produces no extra output.
- R9: While `enable`=0, no sample is accepted, any job in progress is dropped, and all delay terms clear to zero.
- R10: Each section output saturates to the range −8388608..8388607 before it feeds the next section.
- R11: Each section keeps its own past inputs x1, x2 and past outputs y1, y2, and updates them after every sample it processes.
- R12: After reset, `busy`, `out_valid` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; when low, the engine is idle and the delay terms are cleared |
| five_stage | input | 1 | 0: six sections, 1: five sections |
| hp_en | input | 1 | High-pass section in use |
| path_pwm | input | 1 | 0: converter-input path (high-pass last), 1: modulator path (high-pass first) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| coef_addr | output | 5 | Coefficient word address |
| coef_data | input | 32 | Coefficient word, valid in the same cycle |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed filtered sample |
| busy | output | 1 | A sample is being processed |

## Verification
The bench builds the engine with its default parameters: 24-bit samples, 32-bit coefficient words with 16 fraction bits, and six stored sections. These are the only values at which the 5/6-section switch and the high-pass placement rule are both meaningful. With those values, the recorded coefficient address sequence reaches every chain-ordering mode. The 24-bit bound is small enough that a 2.0 gain in one section saturates an internal stage that a later 0.5 gain would otherwise hide.

// File: rtl/iir_pkg.sv
package iir_pkg;
   localparam int TAPS = 5;
   typedef enum logic [2:0] {
      TAP_B0 = 3'd0,
      TAP_B1 = 3'd1,
      TAP_B2 = 3'd2,
      TAP_A1 = 3'd3,
      TAP_A2 = 3'd4
   } tap_e;
endpackage

// File: rtl/iir_sect_map.sv
module iir_sect_map #(
   parameter int NSECT = 6,
   localparam int SW = $clog2(NSECT)
) (
   input  logic [SW-1:0] pos,
   input  logic          five_stage,
   input  logic          hp_en,
   input  logic          path_pwm,
   output logic [SW-1:0] phys,
   output logic          last
);
   if (NSECT < 2) begin : g_bad_nsect
      $error("iir_sect_map: NSECT must be at least 2");
   end

   localparam logic [SW-1:0] FULL_LAST  = SW'(NSECT - 1);
   localparam logic [SW-1:0] SHORT_LAST = SW'(NSECT - 2);

   logic [SW-1:0] last_pos;

   always_comb begin
      last_pos = five_stage ? SHORT_LAST : FULL_LAST;
      last     = (pos == last_pos);
      // converter path: the high-pass slot is the top stored section, run last
      if (hp_en && !path_pwm && last) phys = FULL_LAST;
      else                            phys = pos;
   end
endmodule

// File: rtl/iir_state_bank.sv
module iir_state_bank
   import iir_pkg::*;
#(
   parameter int DW    = 24,
   parameter int NSECT = 6,
   localparam int SW = $clog2(NSECT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr_en,
   input  logic [SW-1:0]        wr_sect,
   input  logic signed [DW-1:0] wr_x,
   input  logic signed [DW-1:0] wr_y,
   input  logic [SW-1:0]        rd_sect,
   input  tap_e                 rd_tap,
   output logic signed [DW-1:0] rd_val
);
   logic signed [DW-1:0] x1_a [NSECT];
   logic signed [DW-1:0] x2_a [NSECT];
   logic signed [DW-1:0] y1_a [NSECT];
   logic signed [DW-1:0] y2_a [NSECT];

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      logic signed [DW-1:0] d_x1, d_x2, d_y1, d_y2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_x1 <= '0; d_x2 <= '0; d_y1 <= '0; d_y2 <= '0;
         end else if (clr) begin
            d_x1 <= '0; d_x2 <= '0; d_y1 <= '0; d_y2 <= '0;
         end else if (wr_en && wr_sect == SW'(s)) begin
            d_x2 <= d_x1;
            d_x1 <= wr_x;
            d_y2 <= d_y1;
            d_y1 <= wr_y;
         end
      end
      assign x1_a[s] = d_x1;
      assign x2_a[s] = d_x2;
      assign y1_a[s] = d_y1;
      assign y2_a[s] = d_y2;
   end

   always_comb begin
      case (rd_tap)
         TAP_B1:  rd_val = x1_a[rd_sect];
         TAP_B2:  rd_val = x2_a[rd_sect];
         TAP_A1:  rd_val = y1_a[rd_sect];
         TAP_A2:  rd_val = y2_a[rd_sect];
         default: rd_val = '0;
      endcase
   end

   // R11: a history write always targets an existing section
   a_r11_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_sect < SW'(NSECT)));
endmodule

// File: rtl/iir_mac.sv
module iir_mac #(
   parameter int DW   = 24,
   parameter int CW   = 32,
   parameter int FRAC = 16,
   localparam int PW    = CW + DW,
   localparam int ACC_W = PW + 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 start,
   input  logic                 sub,
   input  logic signed [CW-1:0] coef,
   input  logic signed [DW-1:0] opnd,
   output logic signed [DW-1:0] res
);
   if (FRAC >= CW || FRAC < 1) begin : g_bad_frac
      $error("iir_mac: FRAC must lie in 1..CW-1");
   end

   localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] prod_x, base, sum, shifted, acc_q;

   always_comb begin
      prod    = coef * opnd;
      prod_x  = $signed({{3{prod[PW-1]}}, prod});
      base    = start ? '0 : acc_q;
      sum     = sub ? (base - prod_x) : (base + prod_x);
      shifted = sum >>> FRAC;
      if (shifted > MAXV)      res = MAXV[DW-1:0];
      else if (shifted < MINV) res = MINV[DW-1:0];
      else                     res = shifted[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q <= '0;
      else if (en) acc_q <= sum;
   end
endmodule

// File: rtl/iir_cascade_engine.sv
module iir_cascade_engine
   import iir_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int COEF_W    = 32,
   parameter int COEF_FRAC = 16,
   parameter int NUM_SECT  = 6,
   localparam int SW     = $clog2(NUM_SECT),
   localparam int WORDS  = NUM_SECT * TAPS,
   localparam int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              five_stage,
   input  logic              hp_en,
   input  logic              path_pwm,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic [ADDR_W-1:0] coef_addr,
   input  logic [COEF_W-1:0] coef_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              busy
);
   if (DATA_W < 8 || COEF_W < 8) begin : g_bad_width
      $error("iir_cascade_engine: widths too small");
   end

   logic                     busy_q, out_v_q;
   logic [SW-1:0]            pos_q;
   tap_e                     tap_q;
   logic signed [DATA_W-1:0] x_cur_q, out_q;
   logic [SW-1:0]            phys;
   logic                     last_sect;
   logic signed [DATA_W-1:0] hist_val, opnd, mac_res;
   logic                     tap_last, wr_en;

   iir_sect_map #(.NSECT(NUM_SECT)) u_map (
      .pos(pos_q), .five_stage(five_stage), .hp_en(hp_en), .path_pwm(path_pwm),
      .phys(phys), .last(last_sect)
   );

   assign tap_last  = (tap_q == TAP_A2);
   assign wr_en     = busy_q && enable && tap_last;
   assign opnd      = (tap_q == TAP_B0) ? x_cur_q : hist_val;
   assign coef_addr = ADDR_W'(int'(phys) * TAPS + int'(tap_q));

   iir_state_bank #(.DW(DATA_W), .NSECT(NUM_SECT)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(!enable),
      .wr_en(wr_en), .wr_sect(phys), .wr_x(x_cur_q), .wr_y(mac_res),
      .rd_sect(phys), .rd_tap(tap_q), .rd_val(hist_val)
   );

   iir_mac #(.DW(DATA_W), .CW(COEF_W), .FRAC(COEF_FRAC)) u_mac (
      .clk(clk), .rst_n(rst_n), .en(busy_q),
      .start(tap_q == TAP_B0), .sub(tap_q == TAP_A1 || tap_q == TAP_A2),
      .coef($signed(coef_data)), .opnd(opnd), .res(mac_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         out_v_q <= 1'b0;
         pos_q   <= '0;
         tap_q   <= TAP_B0;
         x_cur_q <= '0;
         out_q   <= '0;
      end else if (!enable) begin
         busy_q  <= 1'b0;
         out_v_q <= 1'b0;
         pos_q   <= '0;
         tap_q   <= TAP_B0;
      end else begin
         out_v_q <= 1'b0;
         if (!busy_q) begin
            if (in_valid) begin
               busy_q  <= 1'b1;
               pos_q   <= '0;
               tap_q   <= TAP_B0;
               x_cur_q <= $signed(in_data);
            end
         end else if (tap_last) begin
            x_cur_q <= mac_res;
            tap_q   <= TAP_B0;
            if (last_sect) begin
               busy_q  <= 1'b0;
               out_v_q <= 1'b1;
               out_q   <= mac_res;
               pos_q   <= '0;
            end else begin
               pos_q <= pos_q + SW'(1);
            end
         end else begin
            tap_q <= tap_e'(tap_q + 3'd1);
         end
      end
   end

   assign busy      = busy_q;
   assign out_valid = out_v_q;
   assign out_data  = out_q;

   // R7: the result strobe never overlaps a job and lasts one cycle
   a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !busy);
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R2: fetch addresses stay inside the coefficient store
   a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (coef_addr < ADDR_W'(WORDS)));
   // R9: disabling drops any job and emits nothing
   a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!busy && !out_valid));
   // R8: a job in progress keeps its sample until the last section
   a_r8_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tap_last && $past(busy)) |=> $stable(x_cur_q) || !enable);
endmodule

// File: tb/sim_iir_cascade_engine.sv
module sim_iir_cascade_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, five_stage = 1'b0, hp_en = 1'b0, path_pwm = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_data = '0;
   logic [4:0]  coef_addr;
   logic [31:0] coef_data;
   logic        out_valid, busy;
   logic [23:0] out_data;

   logic [31:0] cmem [30];
   int          checks = 0, errors = 0;
   int          alog [40];
   int          acnt;
   int          cycles = 0;

   always #2.5 clk = ~clk;

   assign coef_data = (coef_addr < 5'd30) ? cmem[coef_addr] : 32'h0;

   iir_cascade_engine u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .five_stage(five_stage),
      .hp_en(hp_en), .path_pwm(path_pwm), .in_valid(in_valid), .in_data(in_data),
      .coef_addr(coef_addr), .coef_data(coef_data), .out_valid(out_valid),
      .out_data(out_data), .busy(busy)
   );

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_identity();
      for (int i = 0; i < 30; i++) cmem[i] = 32'h0;
      for (int s = 0; s < 6; s++) cmem[s*5] = 32'h0001_0000;
   endtask

   task automatic clear_hist();
      @(negedge clk) enable = 1'b0;
      @(negedge clk) enable = 1'b1;
   endtask

   // one sample; returns output, latency in edges, and extra strobes seen after
   task automatic run(input int x, input bit inject, output int y, output int lat, output int extra);
      acnt = 0; extra = 0;
      @(negedge clk) begin in_valid = 1'b1; in_data = 24'(x); end
      @(negedge clk) in_valid = 1'b0;
      lat = 0;
      while (!out_valid && lat < 100) begin
         if (busy && acnt < 40) begin alog[acnt] = int'(coef_addr); acnt++; end
         if (inject && lat == 3) begin in_valid = 1'b1; in_data = 24'h00_1234; end
         @(negedge clk) begin lat++; in_valid = 1'b0; end
      end
      y = int'($signed(out_data));
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (out_valid || busy) extra++;
      end
   endtask

   task automatic check_order(input int n, input bit hp, input bit pwm, input string req);
      bit ok = (acnt == n*5);
      int k = 0;
      for (int p = 0; p < n; p++) begin
         int ph = (hp && !pwm && p == n-1) ? 5 : p;
         for (int t = 0; t < 5; t++) begin
            if (k < acnt && alog[k] != ph*5 + t) ok = 1'b0;
            k++;
         end
      end
      chk(int'(ok), 1, req);
   endtask

   task automatic t_reset();
      chk(int'(busy), 0, "R12 busy");
      chk(int'(out_valid), 0, "R12 out_valid");
      chk(int'(out_data), 0, "R12 out_data");
   endtask

   task automatic t_six();
      int y, lat, ex;
      set_identity(); five_stage = 0; hp_en = 0; clear_hist();
      run(-5000, 0, y, lat, ex);
      chk(y, -5000, "R1 identity");
      chk(lat, 30, "R7 latency six");
      check_order(6, 0, 0, "R3 order six");
      check_order(6, 0, 0, "R2 tap order");
   endtask

   task automatic t_gain();
      int y, lat, ex;
      set_identity(); cmem[0] = 32'h0000_8000; clear_hist();
      run(1001, 0, y, lat, ex);
      chk(y, 500, "R1 half gain positive");
      run(-1001, 0, y, lat, ex);
      chk(y, -501, "R1 half gain floor negative");
   endtask

   task automatic t_five();
      int y, lat, ex;
      set_identity(); cmem[25] = 32'h0000_8000; five_stage = 1; hp_en = 0; clear_hist();
      run(4000, 0, y, lat, ex);
      chk(y, 4000, "R4 section five unused");
      chk(lat, 25, "R7 latency five");
      check_order(5, 0, 0, "R4 order five");
   endtask

   task automatic t_hp_adc();
      int y, lat, ex;
      set_identity(); cmem[25] = 32'h0000_8000; five_stage = 1; hp_en = 1; path_pwm = 0; clear_hist();
      run(4000, 0, y, lat, ex);
      chk(y, 2000, "R5 high-pass slot last");
      check_order(5, 1, 0, "R5 order adc");
      five_stage = 0; clear_hist();
      run(4000, 0, y, lat, ex);
      check_order(6, 1, 0, "R5 order adc six");
   endtask

   task automatic t_hp_pwm();
      int y, lat, ex;
      set_identity(); cmem[25] = 32'h0000_8000; five_stage = 1; hp_en = 1; path_pwm = 1; clear_hist();
      run(4000, 0, y, lat, ex);
      chk(y, 4000, "R6 high-pass first");
      check_order(5, 1, 1, "R6 order pwm");
      hp_en = 0; path_pwm = 0; five_stage = 0;
   endtask

   task automatic t_history();
      int y, lat, ex;
      set_identity(); cmem[10] = 32'h0; cmem[12] = 32'h0001_0000; clear_hist();
      run(111, 0, y, lat, ex); chk(y, 0, "R11 x2 first");
      run(222, 0, y, lat, ex); chk(y, 0, "R11 x2 second");
      run(333, 0, y, lat, ex); chk(y, 111, "R11 x2 delayed");
      set_identity(); cmem[3] = 32'hFFFF_8000; clear_hist();
      run(1000, 0, y, lat, ex); chk(y, 1000, "R11 feedback start");
      run(0, 0, y, lat, ex);    chk(y, 500, "R11 feedback y1");
      clear_hist();
      run(0, 0, y, lat, ex);    chk(y, 0, "R9 history cleared");
   endtask

   task automatic t_sat();
      int y, lat, ex;
      set_identity(); cmem[0] = 32'h0002_0000; cmem[5] = 32'h0000_8000; clear_hist();
      run(5000000, 0, y, lat, ex);  chk(y, 4194303, "R10 saturate high");
      run(-5000000, 0, y, lat, ex); chk(y, -4194304, "R10 saturate low");
   endtask

   task automatic t_busy();
      int y, lat, ex;
      set_identity(); clear_hist();
      run(777, 1, y, lat, ex);
      chk(y, 777, "R8 result kept");
      chk(ex, 0, "R8 no extra output");
   endtask

   task automatic t_disable();
      int seen = 0;
      @(negedge clk) begin enable = 1'b0; in_valid = 1'b1; in_data = 24'd55; end
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (out_valid || busy) seen++;
      end
      in_valid = 1'b0;
      chk(seen, 0, "R9 disabled no processing");
      enable = 1'b1;
   endtask

   initial begin
      set_identity();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk) enable = 1'b1;
      t_six();
      t_gain();
      t_five();
      t_hp_adc();
      t_hp_pwm();
      t_history();
      t_sat();
      t_busy();
      t_disable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule